// File: doc/BRIEF.md
# Pipelined Q-Table Update Engine

This block keeps the action-value table of a small discrete reinforcement-learning task and applies one temporal-difference update for every transition it receives. The caller offers a transition made of the visited state, the action taken, the reward that followed and the state reached, together with the discount and learning-rate factors to use for it. The block looks up all four action values of the reached state at once, picks the largest, forms the TD error, scales it by the learning rate and writes the corrected value back into the table.

The table is split into four banks, one per action, each indexed by state. A whole row is therefore read in a single cycle. Transitions flow through a three-stage pipeline, and one can be accepted on every clock. A later transition may read an entry that an earlier one has not yet written. In that case the pending value is forwarded, so the results always match a strictly one-after-another execution. Each retired update reports the best value and best action found in the reached state, the TD error and the new entry value.

All values are signed 16-bit fixed point with 8 fraction bits. Choosing actions, exploration and the environment are left to the surrounding logic.

Top module: `qlu_engine`

## Requirements
- R1: While `rst` is high and in the cycle after, `out_valid` and `in_ready` are low, and every table entry is cleared to zero.
- R2: The entry of state s and action a is row s of bank a, where bank a is selected by the 2-bit action code; every result reports the state and action of the transition it belongs to.
- R3: `out_max` is the largest of the four values of the reached state, and `out_best` is its action code; on ties the lowest action code wins, because only a strictly larger value replaces the current best.
- R4: `out_tderr` equals reward + trunc(gamma × out_max) − Q(state, action), with every addition and subtraction wrapping in 16 bits and no saturation.
- R5: `out_qnew` equals Q(state, action) + trunc(alpha × out_tderr), where trunc keeps bits [23:8] of the full signed 32-bit product.
- R6: Gamma and alpha are captured with each accepted transition, so neighbouring transitions may use different factors without affecting one another.
- R7: Once out of reset, `in_ready` stays high; a transition is accepted in any cycle in which `in_valid` is high, and its result appears on the outputs exactly three clock edges after the accepting edge, in acceptance order.
- R8: When a transition reads an entry that an earlier transition still in flight will write, the newer pending value is used, so back-to-back dependent updates give the same results as serial execution.
- R9: `out_qnew` is written into the table entry of the reported state and action, and later transitions observe it.
- R10: Cycles with `in_valid` low change no table entry and produce no result, whatever values the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A transition is offered |
| in_ready | output | 1 | The engine can take a transition |
| in_state | input | 4 | State in which the action was taken |
| in_action | input | 2 | Action taken |
| in_reward | input | 16 | Reward received, signed fixed point, 8 fraction bits |
| in_next | input | 4 | State reached |
| in_gamma | input | 16 | Discount factor for this transition, signed fixed point |
| in_alpha | input | 16 | Learning rate for this transition, signed fixed point |
| out_valid | output | 1 | An update retires this cycle |
| out_state | output | 4 | State of the retired update |
| out_action | output | 2 | Action of the retired update |
| out_max | output | 16 | Largest value of the reached state |
| out_best | output | 2 | Action holding that largest value |
| out_tderr | output | 16 | TD error of the update |
| out_qnew | output | 16 | Value written into the table |

## Verification
Some properties are checked on every cycle by assertions. These are that the maximum search never leaves a larger value unpicked and resolves ties toward the lowest action, that results come out only three edges after an acceptance, that readiness is never withdrawn, and that reset leaves the outputs idle. Other behaviours show only in the bench's scenarios, which compare each result against a serial bit-exact model. These are the arithmetic itself (truncated products, wrapping sums), forwarding across back-to-back dependent transitions, per-transition factors, and the fact that idle cycles leave the table untouched.

// File: rtl/qlu_pkg.sv
package qlu_pkg;

    localparam int NSTATE = 16;
    localparam int NACT   = 4;
    localparam int QW     = 16;
    localparam int FRAC   = 8;
    localparam int SW     = $clog2(NSTATE);
    localparam int AW     = $clog2(NACT);
    localparam int PW     = 2 * QW;

    typedef logic signed [QW-1:0] qval_t;
    typedef logic [SW-1:0]        st_t;
    typedef logic [AW-1:0]        act_t;

    // transition captured at acceptance
    typedef struct packed {
        st_t   state;
        act_t  action;
        qval_t reward;
        st_t   next;
        qval_t gamma;
        qval_t alpha;
    } xfer_t;

    // after lookup and maximum search
    typedef struct packed {
        st_t   state;
        act_t  action;
        qval_t reward;
        qval_t gamma;
        qval_t alpha;
        qval_t qcur;
        qval_t vmax;
        act_t  best;
    } look_t;

    // ready to be written back
    typedef struct packed {
        st_t   state;
        act_t  action;
        qval_t vmax;
        act_t  best;
        qval_t td;
        qval_t qnew;
    } wb_t;

    // fixed-point product: full-width signed multiply, keep bits [FRAC+QW-1:FRAC]
    function automatic qval_t fx_mul(qval_t a, qval_t b);
        logic signed [PW-1:0] p;
        p = PW'(a) * PW'(b);
        return qval_t'(p >>> FRAC);
    endfunction

endpackage

// File: rtl/qlu_bank.sv
module qlu_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int AB   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AB-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AB-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AB-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // asynchronous read: a write lands at the clock edge, readers see it afterwards
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/qlu_argmax.sv
module qlu_argmax
    import qlu_pkg::*;
(
    input  qval_t vals [NACT],
    output qval_t vmax,
    output act_t  best
);

    always_comb begin
        vmax = vals[0];
        best = '0;
        for (int i = 1; i < NACT; i++) begin
            if (vals[i] > vmax) begin
                vmax = vals[i];
                best = act_t'(i);
            end
        end
    end

    // independent views of the search result
    logic bound_ok;
    logic tie_ok;
    always_comb begin
        bound_ok = 1'b1;
        tie_ok   = 1'b1;
        for (int i = 0; i < NACT; i++) begin
            if (vals[i] > vmax) bound_ok = 1'b0;
            if ((i < int'(best)) && (vals[i] == vmax)) tie_ok = 1'b0;
        end
    end

    always_comb begin
        AST_MAX_IS_UPPER_BOUND: assert (bound_ok) else $error("larger value left unpicked"); // R3
        AST_BEST_HOLDS_MAX: assert (vals[best] == vmax) else $error("best action does not hold max"); // R3
        AST_TIE_TO_LOWEST: assert (tie_ok) else $error("tie not resolved to lowest action"); // R3
    end

endmodule

// File: rtl/qlu_tdcalc.sv
module qlu_tdcalc
    import qlu_pkg::*;
(
    input  qval_t reward,
    input  qval_t gamma,
    input  qval_t alpha,
    input  qval_t vmax,
    input  qval_t qcur,
    output qval_t td,
    output qval_t qnew
);

    qval_t disc;
    qval_t step;

    always_comb begin
        disc = fx_mul(gamma, vmax);
        td   = reward + disc - qcur;
        step = fx_mul(alpha, td);
        qnew = qcur + step;
    end

endmodule

// File: rtl/qlu_engine.sv
module qlu_engine
    import qlu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SW-1:0]     in_state,
    input  logic [AW-1:0]     in_action,
    input  logic [QW-1:0]     in_reward,
    input  logic [SW-1:0]     in_next,
    input  logic [QW-1:0]     in_gamma,
    input  logic [QW-1:0]     in_alpha,
    output logic              out_valid,
    output logic [SW-1:0]     out_state,
    output logic [AW-1:0]     out_action,
    output logic [QW-1:0]     out_max,
    output logic [AW-1:0]     out_best,
    output logic [QW-1:0]     out_tderr,
    output logic [QW-1:0]     out_qnew
);

    logic rdy_q;
    logic take;

    logic  s1_v, s2_v, s3_v;
    xfer_t s1_x;
    look_t s2_x;
    wb_t   s3_x;

    always_ff @(posedge clk) begin
        rdy_q <= !rst;
    end

    assign in_ready = rdy_q;
    assign take     = in_valid && rdy_q;

    // ---------------- stage 1: capture ----------------
    always_ff @(posedge clk) begin
        if (rst) s1_v <= 1'b0;
        else     s1_v <= take;
        if (take) begin
            s1_x.state  <= in_state;
            s1_x.action <= in_action;
            s1_x.reward <= qval_t'(in_reward);
            s1_x.next   <= in_next;
            s1_x.gamma  <= qval_t'(in_gamma);
            s1_x.alpha  <= qval_t'(in_alpha);
        end
    end

    // ---------------- banked table ----------------
    qval_t row_next [NACT];
    qval_t row_cur  [NACT];
    qval_t s2_qnew;
    qval_t s2_td;

    for (genvar a = 0; a < NACT; a++) begin : g_bank
        logic [QW-1:0] rd_a, rd_b;
        qlu_bank #(.DEPTH(NSTATE), .W(QW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (s3_v && (s3_x.action == act_t'(a))),
            .waddr   (s3_x.state),
            .wdata   (s3_x.qnew),
            .raddr_a (s1_x.next),
            .rdata_a (rd_a),
            .raddr_b (s1_x.state),
            .rdata_b (rd_b)
        );
        assign row_next[a] = qval_t'(rd_a);
        assign row_cur[a]  = qval_t'(rd_b);
    end

    // ---------------- forwarding ----------------
    // youngest in-flight writer (stage 2) wins over stage 3, which wins over the table
    function automatic qval_t pick(st_t s, act_t a, qval_t stored,
                                   logic v2, st_t st2, act_t ac2, qval_t val2,
                                   logic v3, st_t st3, act_t ac3, qval_t val3);
        if (v2 && st2 == s && ac2 == a) return val2;
        if (v3 && st3 == s && ac3 == a) return val3;
        return stored;
    endfunction

    qval_t fw_next [NACT];
    qval_t fw_cur;

    always_comb begin
        for (int a = 0; a < NACT; a++) begin
            fw_next[a] = pick(s1_x.next, act_t'(a), row_next[a],
                              s2_v, s2_x.state, s2_x.action, s2_qnew,
                              s3_v, s3_x.state, s3_x.action, s3_x.qnew);
        end
        fw_cur = pick(s1_x.state, s1_x.action, row_cur[s1_x.action],
                      s2_v, s2_x.state, s2_x.action, s2_qnew,
                      s3_v, s3_x.state, s3_x.action, s3_x.qnew);
    end

    qval_t s1_max;
    act_t  s1_best;

    qlu_argmax u_max (
        .vals (fw_next),
        .vmax (s1_max),
        .best (s1_best)
    );

    // ---------------- stage 2: lookup result ----------------
    always_ff @(posedge clk) begin
        if (rst) s2_v <= 1'b0;
        else     s2_v <= s1_v;
        if (s1_v) begin
            s2_x.state  <= s1_x.state;
            s2_x.action <= s1_x.action;
            s2_x.reward <= s1_x.reward;
            s2_x.gamma  <= s1_x.gamma;
            s2_x.alpha  <= s1_x.alpha;
            s2_x.qcur   <= fw_cur;
            s2_x.vmax   <= s1_max;
            s2_x.best   <= s1_best;
        end
    end

    qlu_tdcalc u_td (
        .reward (s2_x.reward),
        .gamma  (s2_x.gamma),
        .alpha  (s2_x.alpha),
        .vmax   (s2_x.vmax),
        .qcur   (s2_x.qcur),
        .td     (s2_td),
        .qnew   (s2_qnew)
    );

    // ---------------- stage 3: write-back ----------------
    always_ff @(posedge clk) begin
        if (rst) s3_v <= 1'b0;
        else     s3_v <= s2_v;
        if (s2_v) begin
            s3_x.state  <= s2_x.state;
            s3_x.action <= s2_x.action;
            s3_x.vmax   <= s2_x.vmax;
            s3_x.best   <= s2_x.best;
            s3_x.td     <= s2_td;
            s3_x.qnew   <= s2_qnew;
        end
    end

    assign out_valid  = s3_v;
    assign out_state  = s3_x.state;
    assign out_action = s3_x.action;
    assign out_max    = s3_x.vmax;
    assign out_best   = s3_x.best;
    assign out_tderr  = s3_x.td;
    assign out_qnew   = s3_x.qnew;

    // ---------------- assertions ----------------
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !in_ready))
        else $error("outputs active right after reset"); // R1

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> in_ready)
        else $error("ready withdrawn"); // R7

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_ready, 3))
        else $error("result without acceptance three edges earlier"); // R7

endmodule

// File: tb/qlu_engine_test.sv
module qlu_engine_test;
    import qlu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_state = '0;
    logic [1:0]  in_action = '0;
    logic [15:0] in_reward = '0;
    logic [3:0]  in_next = '0;
    logic [15:0] in_gamma = '0;
    logic [15:0] in_alpha = '0;
    logic        out_valid;
    logic [3:0]  out_state;
    logic [1:0]  out_action;
    logic [15:0] out_max;
    logic [1:0]  out_best;
    logic [15:0] out_tderr;
    logic [15:0] out_qnew;

    always #2 clk = ~clk;

    qlu_engine uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_state(in_state), .in_action(in_action), .in_reward(in_reward),
        .in_next(in_next), .in_gamma(in_gamma), .in_alpha(in_alpha),
        .out_valid(out_valid), .out_state(out_state), .out_action(out_action),
        .out_max(out_max), .out_best(out_best), .out_tderr(out_tderr),
        .out_qnew(out_qnew)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [3:0]  s;
        logic [1:0]  a;
        logic [15:0] mx;
        logic [1:0]  bst;
        logic [15:0] td;
        logic [15:0] qn;
    } exp_t;

    exp_t expq[$];
    logic signed [15:0] tbl [16][4];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [15:0] mul(logic signed [15:0] x, logic signed [15:0] y);
        logic signed [31:0] p;
        p = 32'(x) * 32'(y);
        return p[23:8];
    endfunction

    // result monitor: compares against the serial model in order
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R7", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(cyc == e.due, "R7", "result cycle", cyc, e.due);
                    chk(out_state == e.s && out_action == e.a, "R2", "state/action",
                        {out_state, out_action}, {e.s, e.a});
                    chk(out_max == e.mx, "R3", "max", $signed(out_max), $signed(e.mx));
                    chk(out_best == e.bst, "R3", "best action", out_best, e.bst);
                    chk(out_tderr == e.td, "R4", "td error", $signed(out_tderr), $signed(e.td));
                    chk(out_qnew == e.qn, "R5", "new value", $signed(out_qnew), $signed(e.qn));
                end
            end else if (expq.size() != 0 && expq[0].due < cyc) begin
                chk(0, "R7", "missing result", cyc, expq[0].due);
                void'(expq.pop_front());
            end
        end
    end

    // offer one transition; called at a negative edge, returns at the next one
    task automatic send(input logic [3:0] s, input logic [1:0] a, input logic [15:0] r,
                        input logic [3:0] n, input logic [15:0] g, input logic [15:0] al);
        exp_t e;
        logic signed [15:0] mx, qc, td;
        logic [1:0] b;
        chk(in_ready == 1'b1, "R7", "ready", in_ready, 1);
        in_valid = 1'b1; in_state = s; in_action = a; in_reward = r;
        in_next = n; in_gamma = g; in_alpha = al;
        mx = tbl[n][0]; b = 2'd0;
        for (int i = 1; i < 4; i++) begin
            if (tbl[n][i] > mx) begin mx = tbl[n][i]; b = 2'(i); end
        end
        qc = tbl[s][a];
        td = $signed(r) + mul($signed(g), mx) - qc;
        e.due = cyc + 3; e.s = s; e.a = a; e.mx = mx; e.bst = b;
        e.td = td; e.qn = qc + mul($signed(al), td);
        tbl[s][a] = e.qn;
        expq.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 20 && expq.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, req, "all results retired", expq.size(), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b0, "R1", "ready in reset", in_ready, 0);
        chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
        for (int s = 0; s < 16; s++) for (int a = 0; a < 4; a++) tbl[s][a] = '0;
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R7", "ready after reset", in_ready, 1);
    endtask

    task automatic t_single();
        // zero table: max 0, best 0 (R1 cleared entries, R3 tie to lowest)
        send(4'd3, 2'd2, 16'sd256, 4'd5, 16'sd230, 16'sd26);
        drain("R5");
        // later read of the written entry (R9)
        send(4'd1, 2'd0, 16'sd0, 4'd3, 16'sd230, 16'sd26);
        drain("R9");
    endtask

    task automatic t_ties();
        // equal values on actions 1 and 3 of state 7: best must be 1 (R3)
        send(4'd7, 2'd3, 16'sd512, 4'd0, 16'sd230, 16'sd26);
        send(4'd7, 2'd1, 16'sd512, 4'd0, 16'sd230, 16'sd26);
        drain("R3");
        send(4'd8, 2'd0, 16'sd0, 4'd7, 16'sd230, 16'sd26);
        drain("R3");
        // all-negative row: max is the least negative
        send(4'd9, 2'd2, -16'sd300, 4'd0, 16'sd230, 16'sd128);
        send(4'd9, 2'd0, -16'sd900, 4'd0, 16'sd230, 16'sd128);
        send(4'd9, 2'd1, -16'sd100, 4'd0, 16'sd230, 16'sd128);
        send(4'd9, 2'd3, -16'sd700, 4'd0, 16'sd230, 16'sd128);
        send(4'd10, 2'd1, 16'sd64, 4'd9, 16'sd230, 16'sd26);
        drain("R3");
    endtask

    task automatic t_forward();
        // same entry back to back, then reading it as next state (R8)
        send(4'd4, 2'd1, 16'sd1000, 4'd4, 16'sd230, 16'sd200);
        send(4'd4, 2'd1, 16'sd1000, 4'd4, 16'sd230, 16'sd200);
        send(4'd4, 2'd1, 16'sd1000, 4'd4, 16'sd230, 16'sd200);
        send(4'd6, 2'd2, 16'sd10, 4'd4, 16'sd230, 16'sd200);
        send(4'd4, 2'd3, 16'sd0, 4'd6, 16'sd230, 16'sd200);
        send(4'd2, 2'd0, 16'sd0, 4'd4, 16'sd230, 16'sd200);
        drain("R8");
    endtask

    task automatic t_params();
        // alternating factors on neighbouring transitions (R6)
        send(4'd11, 2'd0, 16'sd256, 4'd4, 16'sd256, 16'sd256);
        send(4'd11, 2'd1, 16'sd256, 4'd4, 16'sd0,   16'sd13);
        send(4'd11, 2'd2, 16'sd256, 4'd4, 16'sd128, 16'sd64);
        send(4'd11, 2'd3, 16'sd256, 4'd4, -16'sd64, 16'sd255);
        drain("R6");
    endtask

    task automatic t_wrap();
        // large rewards with unity factors force 16-bit wraparound (R4)
        for (int i = 0; i < 5; i++)
            send(4'd12, 2'd0, 16'h7F00, 4'd12, 16'sd256, 16'sd256);
        send(4'd13, 2'd2, 16'h8100, 4'd12, 16'sd256, 16'sd256);
        drain("R4");
    endtask

    task automatic t_idle();
        // garbage on the inputs with in_valid low must change nothing (R10)
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b0; in_state = 4'(i); in_action = 2'(i);
            in_reward = 16'h7FFF; in_next = 4'(15 - i);
            in_gamma = 16'h0100; in_alpha = 16'h0100;
            @(negedge clk);
            chk(out_valid == 1'b0, "R10", "no result while idle", out_valid, 0);
        end
        for (int s = 0; s < 10; s++) send(4'd15, 2'd0, 16'sd0, 4'(s), 16'sd256, 16'sd0);
        drain("R10");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            send(4'(r[3:0] & 4'h7), r[5:4], {{6{r[15]}}, r[15:6]}, 4'(r[19:16] & 4'h7),
                 16'(r[27:20]), 16'(r[31:28]) << 4);
            if (r[7:6] == 2'b00) @(negedge clk);
        end
        drain("R7");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_ties();
        t_forward();
        t_params();
        t_wrap();
        t_idle();
        t_stream();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule